// File: doc/BRIEF.md
# Three-Port Deflection Routing Switch Node

This block is one node of a packet network in which messages are never queued. Each node has three ports that each carry one message in and one message out per cycle. Every message that arrives in a cycle leaves in the next cycle, on some output. A small programmable table in the node turns the recipient address of each message into the output port that moves the message closer to its recipient.

When two or three messages want the same output, the one with the highest priority gets it. The others are deflected onto outputs that are still free, even though those outputs lead the wrong way. Each deflected message has its priority raised by one, so a message that is pushed aside often ends up winning. The priority stops at its maximum value and does not wrap, so a message at that ceiling wins against every message below it.

The input side has no back-pressure. There is no ready signal, and a valid input is always accepted in the cycle it is presented. This holds because three inputs can always be placed on three outputs. Downstream logic must accept every output message in the cycle it appears.

Top module: `dfl_switch_node`

## Requirements
- R1: A message is 23 bits wide, laid out as follows: recipient address in bits [22:15], originator address in bits [14:7], operation code in bits [6:3], priority in bits [2:0]. Port p of `in_msg` and of `out_msg` occupies bits [p*23+22 : p*23].
- R2: A message presented with its valid bit set at a rising clock edge appears on an output in the cycle after that edge. An output whose port received no message in that cycle shows valid low in the same cycle.
- R3: The number of output valid bits set in a cycle equals the number of input valid bits set in the cycle before. No message is dropped or duplicated.
- R4: A message that does not lose a conflict leaves on the port its table entry names. All of its fields, priority included, are unchanged.
- R5: When messages compete for a port, the one with the highest priority wins. Between equal priorities, the lower input port index wins.
- R6: Messages are placed in precedence order, which is highest priority first and then lowest input index. Each message takes its preferred port if that port is still free, and otherwise takes the lowest-numbered free port. No output carries two messages.
- R7: A message that leaves on a port other than its preferred one has its priority raised by one. A priority of 7 stays at 7.
- R8: A table entry of 3 means that no port is preferred. The message takes the lowest-numbered free port at its turn in the order, and it counts as deflected, so its priority is raised under R7.
- R9: When `cfg_we` is high at a clock edge, the table entry at `cfg_addr` becomes `cfg_port`. Lookups in the same cycle still use the old entry, and lookups from the next cycle on use the new one.
- R10: While `rst_n` is low, all output valid bits are low and every table entry is 0 (port 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 8 | Recipient address of the table entry to write |
| cfg_port | input | 2 | Port number to store (3 = no preferred port) |
| in_valid | input | 3 | Per-port input message valid |
| in_msg | input | 69 | Three packed input messages, port 0 in the low bits |
| out_valid | output | 3 | Per-port output message valid |
| out_msg | output | 69 | Three packed output messages, port 0 in the low bits |

## Verification
Some properties are checked by assertions on every cycle:
- the message count is conserved from input to output;
- no output port is granted to two inputs;
- the precedence order produced by the ranking stage never puts a weaker key ahead of a stronger one;
- a saturated priority stays at 7 through a deflection;
- a table write lands at the written address.

Other behaviour can only be shown by the bench's directed scenarios: which port each message actually leaves on, the exact values of deflected priorities, tie-breaking by input index, and the rule that a same-cycle write is not yet seen by a lookup. These need expected values worked out by hand from the requirements, so the bench checks them directly.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int ADDR_W = 8;
  localparam int OP_W   = 4;
  localparam int PRIO_W = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [OP_W-1:0]   op;
    logic [PRIO_W-1:0] prio;
  } msg_t;

  localparam int MSG_W = $bits(msg_t);
endpackage

// File: rtl/dfl_route_table.sv
module dfl_route_table #(
  parameter int NPORT  = 3,
  parameter int ADDR_W = 8,
  parameter int PORT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [PORT_W-1:0]        cfg_port,
  input  logic [NPORT*ADDR_W-1:0]  lk_addr,
  output logic [NPORT*PORT_W-1:0]  lk_port
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PORT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (cfg_we) begin
      mem[cfg_addr] <= cfg_port;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_lookup
    assign lk_port[g*PORT_W +: PORT_W] = mem[lk_addr[g*ADDR_W +: ADDR_W]];
  end

  // R9
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> mem[$past(cfg_addr)] == $past(cfg_port));
endmodule

// File: rtl/dfl_rank.sv
module dfl_rank #(
  parameter int NPORT  = 3,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*PRIO_W-1:0] in_prio,
  output logic [NPORT*IDX_W-1:0]  order
);
  logic [PRIO_W:0] key [NPORT];
  int              rank_a [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      key[i] = {in_valid[i], in_prio[i*PRIO_W +: PRIO_W]};
    end
    for (int i = 0; i < NPORT; i++) begin
      rank_a[i] = 0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && (key[j] > key[i] || (key[j] == key[i] && j < i)))
          rank_a[i] = rank_a[i] + 1;
      end
    end
    order = '0;
    for (int r = 0; r < NPORT; r++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (rank_a[i] == r) order[r*IDX_W +: IDX_W] = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dfl_assign.sv
module dfl_assign #(
  parameter int NPORT  = 3,
  parameter int PORT_W = 2,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         in_valid,
  input  logic [NPORT*PORT_W-1:0]  pref,
  input  logic [NPORT*PRIO_W-1:0]  in_prio,
  input  logic [NPORT*IDX_W-1:0]   order,
  output logic [NPORT*PORT_W-1:0]  sel_port,
  output logic [NPORT*PRIO_W-1:0]  new_prio,
  output logic [NPORT-1:0]         defl
);
  localparam int SLOTS = 1 << PORT_W;
  localparam logic [PRIO_W-1:0] PMAX = '1;

  logic [SLOTS-1:0] taken;

  always_comb begin
    int idx;
    int want;
    int port;
    logic found;
    taken    = '0;
    sel_port = '0;
    defl     = '0;
    for (int r = 0; r < NPORT; r++) begin
      idx  = int'(order[r*IDX_W +: IDX_W]);
      want = int'(pref[idx*PORT_W +: PORT_W]);
      port = 0;
      found = 1'b0;
      if (in_valid[idx]) begin
        if (want < NPORT && !taken[want]) begin
          port = want;
        end else begin
          defl[idx] = 1'b1;
          for (int j = 0; j < NPORT; j++) begin
            if (!found && !taken[j]) begin
              port  = j;
              found = 1'b1;
            end
          end
        end
        taken[port] = 1'b1;
        sel_port[idx*PORT_W +: PORT_W] = PORT_W'(port);
      end
    end
    for (int i = 0; i < NPORT; i++) begin
      if (defl[i] && in_prio[i*PRIO_W +: PRIO_W] != PMAX)
        new_prio[i*PRIO_W +: PRIO_W] = in_prio[i*PRIO_W +: PRIO_W] + 1'b1;
      else
        new_prio[i*PRIO_W +: PRIO_W] = in_prio[i*PRIO_W +: PRIO_W];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_col
    logic [NPORT-1:0] col;
    for (genvar i = 0; i < NPORT; i++) begin : g_row
      assign col[i] = in_valid[i] && (sel_port[i*PORT_W +: PORT_W] == PORT_W'(p));
    end
    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_sat
    // R7
    prio_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_prio[i*PRIO_W +: PRIO_W] == PMAX)
        |-> new_prio[i*PRIO_W +: PRIO_W] == PMAX);
  end
endmodule

// File: rtl/dfl_switch_node.sv
module dfl_switch_node
  import dfl_pkg::*;
#(
  parameter  int NPORT  = 3,
  localparam int PORT_W = $clog2(NPORT + 1),
  localparam int IDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int MW     = MSG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [NPORT-1:0]     in_valid,
  input  logic [NPORT*MW-1:0]  in_msg,
  output logic [NPORT-1:0]     out_valid,
  output logic [NPORT*MW-1:0]  out_msg
);
  msg_t                    in_m [NPORT];
  logic [NPORT*ADDR_W-1:0] lk_addr;
  logic [NPORT*PORT_W-1:0] pref;
  logic [NPORT*PRIO_W-1:0] prio_in;
  logic [NPORT*IDX_W-1:0]  order;
  logic [NPORT*PORT_W-1:0] sel_port;
  logic [NPORT*PRIO_W-1:0] new_prio;
  logic [NPORT-1:0]        defl;
  logic [NPORT-1:0]        nxt_v;
  msg_t                    nxt_m [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_unpack
    assign in_m[g] = msg_t'(in_msg[g*MW +: MW]);
    assign lk_addr[g*ADDR_W +: ADDR_W] = in_m[g].dst;
    assign prio_in[g*PRIO_W +: PRIO_W] = in_m[g].prio;
  end

  dfl_route_table #(.NPORT(NPORT), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_port(cfg_port), .lk_addr(lk_addr), .lk_port(pref)
  );

  dfl_rank #(.NPORT(NPORT), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
    .in_valid(in_valid), .in_prio(prio_in), .order(order)
  );

  dfl_assign #(.NPORT(NPORT), .PORT_W(PORT_W), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_assign (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pref(pref),
    .in_prio(prio_in), .order(order), .sel_port(sel_port),
    .new_prio(new_prio), .defl(defl)
  );

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      nxt_v[p] = 1'b0;
      nxt_m[p] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (in_valid[i] && sel_port[i*PORT_W +: PORT_W] == PORT_W'(p)) begin
          nxt_v[p]      = 1'b1;
          nxt_m[p]      = in_m[i];
          nxt_m[p].prio = new_prio[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    msg_t msg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid[p] <= 1'b0;
        msg_q        <= '0;
      end else begin
        out_valid[p] <= nxt_v[p];
        msg_q        <= nxt_m[p];
      end
    end
    assign out_msg[p*MW +: MW] = msg_q;
  end

  // R3
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(out_valid) == $countones($past(in_valid)));

  logic [PRIO_W:0] ord_key [NPORT];
  always_comb begin
    for (int r = 0; r < NPORT; r++) begin
      ord_key[r] = {in_valid[order[r*IDX_W +: IDX_W]],
                    prio_in[order[r*IDX_W +: IDX_W]*PRIO_W +: PRIO_W]};
    end
  end

  for (genvar r = 0; r + 1 < NPORT; r++) begin : g_ord
    // R5
    rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_key[r] >= ord_key[r+1]);
  end
endmodule

// File: tb/dfl_switch_node_bench.sv
module dfl_switch_node_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_port;
  logic [2:0]  in_valid;
  logic [68:0] in_msg;
  logic [2:0]  out_valid;
  logic [68:0] out_msg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dfl_switch_node u_dfl_switch_node (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_port(cfg_port), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(out_valid), .out_msg(out_msg)
  );

  function automatic logic [22:0] mk(input logic [7:0] d, input logic [7:0] s,
                                     input logic [3:0] o, input logic [2:0] p);
    return {d, s, o, p};
  endfunction

  task automatic chk(input string req, input int p, input logic v_exp, input logic [22:0] m_exp);
    checks++;
    if (out_valid[p] !== v_exp || (v_exp && out_msg[p*23 +: 23] !== m_exp)) begin
      errors++;
      $display("FAIL %s port%0d: got valid=%b msg=%h, expected valid=%b msg=%h",
               req, p, out_valid[p], out_msg[p*23 +: 23], v_exp, m_exp);
    end
  endtask

  task automatic send(input logic [2:0] v, input logic [22:0] a, input logic [22:0] b,
                      input logic [22:0] c);
    @(negedge clk);
    in_valid = v;
    in_msg   = {c, b, a};
    @(posedge clk);
    #1;
  endtask

  task automatic prog(input logic [7:0] a, input logic [1:0] p);
    @(negedge clk);
    in_valid = 3'b000;
    cfg_we   = 1'b1;
    cfg_addr = a;
    cfg_port = p;
    @(posedge clk);
    #1;
    cfg_we   = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_port = '0;
    in_valid = 3'b111;
    in_msg = {mk(8'h05, 8'h01, 4'h1, 3'd1), mk(8'h06, 8'h02, 4'h2, 3'd2), mk(8'h07, 8'h03, 4'h3, 3'd3)};
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 3; p++) chk("R10 reset valid", p, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: cleared table sends any recipient to port 0
    send(3'b010, '0, mk(8'h77, 8'h11, 4'h9, 3'd2), '0);
    chk("R10 table zero", 0, 1'b1, mk(8'h77, 8'h11, 4'h9, 3'd2));
    chk("R2 idle port", 1, 1'b0, '0);
  endtask

  task automatic t_direct();
    send(3'b111, mk(8'h30, 8'hA1, 4'h5, 3'd4), mk(8'h10, 8'hB2, 4'h6, 3'd1),
         mk(8'h20, 8'hC3, 4'h7, 3'd0));
    // R4 R1: each goes to its table port with fields intact
    chk("R4 direct", 2, 1'b1, mk(8'h30, 8'hA1, 4'h5, 3'd4));
    chk("R4 direct", 0, 1'b1, mk(8'h10, 8'hB2, 4'h6, 3'd1));
    chk("R1 direct", 1, 1'b1, mk(8'h20, 8'hC3, 4'h7, 3'd0));
  endtask

  task automatic t_contend();
    send(3'b111, mk(8'h20, 8'h01, 4'h1, 3'd2), mk(8'h20, 8'h02, 4'h2, 3'd5),
         mk(8'h20, 8'h03, 4'h3, 3'd5));
    chk("R5 winner", 1, 1'b1, mk(8'h20, 8'h02, 4'h2, 3'd5));
    chk("R6 R7 second", 0, 1'b1, mk(8'h20, 8'h03, 4'h3, 3'd6));
    chk("R6 R7 third", 2, 1'b1, mk(8'h20, 8'h01, 4'h1, 3'd3));
  endtask

  task automatic t_saturate();
    send(3'b111, mk(8'h10, 8'h01, 4'h1, 3'd7), mk(8'h10, 8'h02, 4'h2, 3'd6),
         mk(8'h10, 8'h03, 4'h3, 3'd7));
    chk("R5 sat winner", 0, 1'b1, mk(8'h10, 8'h01, 4'h1, 3'd7));
    chk("R7 sat hold", 1, 1'b1, mk(8'h10, 8'h03, 4'h3, 3'd7));
    chk("R7 bump to max", 2, 1'b1, mk(8'h10, 8'h02, 4'h2, 3'd7));
  endtask

  task automatic t_tie();
    send(3'b101, mk(8'h30, 8'h0A, 4'h4, 3'd3), mk(8'h30, 8'h0B, 4'h4, 3'd7),
         mk(8'h30, 8'h0C, 4'h4, 3'd3));
    chk("R5 tie low index", 2, 1'b1, mk(8'h30, 8'h0A, 4'h4, 3'd3));
    chk("R6 tie loser", 0, 1'b1, mk(8'h30, 8'h0C, 4'h4, 3'd4));
    chk("R3 invalid ignored", 1, 1'b0, '0);
  endtask

  task automatic t_noroute();
    send(3'b011, mk(8'h10, 8'h21, 4'h2, 3'd0), mk(8'h40, 8'h22, 4'h3, 3'd5), '0);
    chk("R8 no route", 0, 1'b1, mk(8'h40, 8'h22, 4'h3, 3'd6));
    chk("R6 displaced", 1, 1'b1, mk(8'h10, 8'h21, 4'h2, 3'd1));
    chk("R3 count", 2, 1'b0, '0);
  endtask

  task automatic t_single();
    send(3'b010, '0, mk(8'hFF, 8'h33, 4'hF, 3'd0), '0);
    chk("R4 single", 1, 1'b1, mk(8'hFF, 8'h33, 4'hF, 3'd0));
    chk("R2 single idle", 0, 1'b0, '0);
    send(3'b000, '0, '0, '0);
    for (int p = 0; p < 3; p++) chk("R2 R3 drain", p, 1'b0, '0);
  endtask

  task automatic t_cfg_same();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h10; cfg_port = 2'd2;
    in_valid = 3'b001;
    in_msg = {23'h0, 23'h0, mk(8'h10, 8'h44, 4'h8, 3'd1)};
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    chk("R9 old entry", 0, 1'b1, mk(8'h10, 8'h44, 4'h8, 3'd1));
    send(3'b001, mk(8'h10, 8'h45, 4'h8, 3'd1), '0, '0);
    chk("R9 new entry", 2, 1'b1, mk(8'h10, 8'h45, 4'h8, 3'd1));
  endtask

  initial begin
    t_reset();
    prog(8'h10, 2'd0);
    prog(8'h20, 2'd1);
    prog(8'h30, 2'd2);
    prog(8'h40, 2'd3);
    prog(8'hFF, 2'd1);
    t_direct();
    t_contend();
    t_saturate();
    t_tie();
    t_noroute();
    t_single();
    t_cfg_same();
    @(negedge clk);
    in_valid = 3'b000;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #160000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule